// File: doc/BRIEF.md
# Independent-Channel Rail Enable Supervisor

This block controls four power rails. Each rail has its own gate-enable output. While the shared enable input is high, each channel's gate-enable simply tracks that channel's own undervoltage-good flag. A channel comes up as soon as its own rail input is good, whatever the other channels are doing. If one flag drops, only that channel's gate falls. The other channels keep running and nothing is latched.

An active-low reset output reports that the whole rail set is healthy. It is released once all four channels have reported "fully on" for a programmed hold time, counted in millisecond ticks. Any interruption clears the hold timer and pulls the reset low again.

Removing the shared enable starts an orderly shutdown. The reset goes low at once and stays low. The gates are then dropped from the highest channel down to the lowest, and each step waits its own programmable number of millisecond ticks. The gate drivers, comparators and delay capacitors are outside this block; their results arrive as digital flags and a tick pulse.

Top module: `rail_en_supervisor`

## Requirements
- R1: While `rst_n` is low, every gate-enable output and `rst_n_o` are low.
- R2: In the running state, each `gate_en_o[i]` equals `uv_ok_i[i]` as sampled on the previous clock edge, independently of the other channels. The running state is entered on the edge after `en_i` is seen high in the off state.
- R3: In the off state (after reset or after a completed shutdown), no gate-enable output rises, whatever the undervoltage-good flags are.
- R4: `rst_n_o` goes high only after `HOLD_MS` tick pulses have been counted while every `full_on_i` and `uv_ok_i` bit and `en_i` are high. With the tick high on every cycle, it rises on the (`HOLD_MS`+1)-th edge. Without ticks it never rises.
- R5: When any `full_on_i` bit goes low, `rst_n_o` is low after the next edge. The hold count then restarts from zero.
- R6: When `uv_ok_i[i]` goes low, `gate_en_o[i]` is low after the next edge and `rst_n_o` is pulled low. The other gates are unaffected.
- R7: When `en_i` goes low, `rst_n_o` is low after the next edge and stays low through the whole shutdown.
- R8: Shutdown drops the gates in the order channel 3, 2, 1, 0. Channel k uses delay `off_dly_i[k*16 +: 16]` in ticks. Counting edges from the one that samples `en_i` low as edge 1, gate k falls on edge 1 + Σ over j from k to 3 of (delay_j + 1), with ticks present on every cycle.
- R9: A step delay of zero lets that step complete on the next edge.
- R10: Once started, a shutdown runs to completion even if `en_i` returns high. With `en_i` high, the block then re-enters the running state one edge after the last gate falls, and the gates follow their flags again on the edge after that.
- R11: During shutdown, a channel whose `uv_ok_i` bit goes low has its gate dropped on the next edge, ahead of its scheduled step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Shared enable; its falling edge starts shutdown |
| uv_ok_i | input | 4 | Per-channel undervoltage-good flags (already synchronized) |
| full_on_i | input | 4 | Per-channel "gate fully on" status |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| off_dly_i | input | 64 | Per-channel turn-off delay in ticks, 16 bits per channel, channel k at bits k*16+15:k*16 |
| gate_en_o | output | 4 | Per-channel gate-enable |
| rst_n_o | output | 1 | Active-low rail-good reset |

## Verification
In the running state, the gate path is swept through all sixteen undervoltage-good patterns. This shows that each gate answers only to its own flag. The hold timer is run three ways: with ticks on every cycle, with ticks stopped, and after a brief status dropout. Together these separate counting ticks from counting cycles, and a restarting count from one that resumes. Shutdown is checked edge by edge with three delay vectors: mixed nonzero and zero delays with enable re-raised mid-sequence, all-zero delays, and long equal delays with one flag dropped mid-sequence. These cases separate the step order, the zero-delay skip, the run-to-completion rule and the early drop of a failed channel.

// File: rtl/rail_en_supervisor_pkg.sv
// Shared types for the rail enable supervisor.
package rail_en_supervisor_pkg;
    // Controller mode: all gates held off, gates tracking flags, or ordered turn-off.
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_SHUT = 2'd2
    } rs_mode_e;
endpackage

// File: rtl/rs_off_sequencer.sv
// Mode controller and turn-off stepper.
// Leaves OFF when enable is high, leaves RUN when enable falls, and in SHUT
// walks channels from NCH-1 down to 0. It issues a one-cycle drop pulse for
// each channel once that channel's tick delay has elapsed.
// Assumes: ms_tick_i is a single-cycle pulse; delays are stable during shutdown.
module rs_off_sequencer
    import rail_en_supervisor_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int DLYW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                ms_tick_i,
    input  logic [NCH*DLYW-1:0] off_dly_i,
    output rs_mode_e            mode_o,
    output logic [NCH-1:0]      drop_o
);
    localparam int STW = (NCH > 1) ? $clog2(NCH) : 1;

    rs_mode_e         mode_q;
    logic [STW-1:0]   step_q;
    logic [DLYW-1:0]  cnt_q;
    logic [DLYW-1:0]  dly_sel;
    logic             step_done;

    // Select the delay of the channel being turned off.
    always_comb begin
        dly_sel   = off_dly_i[step_q*DLYW +: DLYW];
        step_done = (mode_q == MODE_SHUT) && (cnt_q == dly_sel);
    end

    // Mode, current step and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            step_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (mode_q)
                MODE_OFF: begin
                    if (en_i) mode_q <= MODE_RUN;
                end
                MODE_RUN: begin
                    if (!en_i) begin
                        mode_q <= MODE_SHUT;
                        step_q <= STW'(NCH - 1);
                        cnt_q  <= '0;
                    end
                end
                MODE_SHUT: begin
                    if (step_done) begin
                        cnt_q <= '0;
                        if (step_q == '0) mode_q <= MODE_OFF;
                        else              step_q <= step_q - STW'(1);
                    end else if (ms_tick_i) begin
                        cnt_q <= cnt_q + DLYW'(1);
                    end
                end
                default: mode_q <= MODE_OFF;
            endcase
        end
    end

    // One-hot drop request for the channel whose step completes.
    always_comb begin
        drop_o = '0;
        if (step_done) drop_o[step_q] = 1'b1;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/rs_gate_lane.sv
// One channel's gate-enable register.
// RUN: follows the channel's undervoltage-good flag. SHUT: can only fall,
// on its drop pulse or on a lost flag. OFF: held low.
// Assumes: uv_ok_i is already synchronized to clk.
module rs_gate_lane
    import rail_en_supervisor_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rs_mode_e mode_i,
    input  logic     uv_ok_i,
    input  logic     drop_i,
    output logic     gate_o
);
    logic gate_q;

    // Gate state per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            case (mode_i)
                MODE_RUN:  gate_q <= uv_ok_i;
                MODE_SHUT: gate_q <= gate_q & uv_ok_i & ~drop_i;
                default:   gate_q <= 1'b0;
            endcase
        end
    end

    assign gate_o = gate_q;
endmodule

// File: rtl/rs_hold_timer.sv
// Rail-good hold timer.
// Counts tick pulses while every channel is good and fully on in RUN with
// enable high. It releases the active-low reset once HOLD_MS ticks are counted.
// Any break clears the count and pulls the reset low on the same edge.
// Assumes: ms_tick_i is a single-cycle pulse.
module rs_hold_timer
    import rail_en_supervisor_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int HOLD_MS = 150
) (
    input  logic           clk,
    input  logic           rst_n,
    input  rs_mode_e       mode_i,
    input  logic           en_i,
    input  logic [NCH-1:0] uv_ok_i,
    input  logic [NCH-1:0] full_on_i,
    input  logic           ms_tick_i,
    output logic           rst_n_o
);
    localparam int HW = $clog2(HOLD_MS + 1);

    logic [HW-1:0] cnt_q;
    logic          healthy;
    logic          rst_q;

    // All conditions for counting toward release.
    always_comb healthy = (mode_i == MODE_RUN) && en_i && (&uv_ok_i) && (&full_on_i);

    // Saturating tick count and registered reset output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rst_q <= 1'b0;
        end else begin
            if (!healthy)                                cnt_q <= '0;
            else if (ms_tick_i && cnt_q != HW'(HOLD_MS)) cnt_q <= cnt_q + HW'(1);
            rst_q <= healthy && (cnt_q == HW'(HOLD_MS));
        end
    end

    assign rst_n_o = rst_q;
endmodule

// File: rtl/rail_en_supervisor.sv
// Four-channel rail enable supervisor, top level.
// Each gate follows its own flag while enabled. A hold timer gates the
// active-low reset, and a stepper runs the reverse-order turn-off.
// Assumes: all inputs synchronous to clk; ms_tick_i single-cycle.
module rail_en_supervisor
    import rail_en_supervisor_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int DLYW    = 16,
    parameter int HOLD_MS = 150
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [NCH-1:0]      uv_ok_i,
    input  logic [NCH-1:0]      full_on_i,
    input  logic                ms_tick_i,
    input  logic [NCH*DLYW-1:0] off_dly_i,
    output logic [NCH-1:0]      gate_en_o,
    output logic                rst_n_o
);
    rs_mode_e       mode_w;
    logic [NCH-1:0] drop_w;

    rs_off_sequencer #(.NCH(NCH), .DLYW(DLYW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .ms_tick_i (ms_tick_i),
        .off_dly_i (off_dly_i),
        .mode_o    (mode_w),
        .drop_o    (drop_w)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        rs_gate_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_i  (mode_w),
            .uv_ok_i (uv_ok_i[i]),
            .drop_i  (drop_w[i]),
            .gate_o  (gate_en_o[i])
        );
    end

    rs_hold_timer #(.NCH(NCH), .HOLD_MS(HOLD_MS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_w),
        .en_i      (en_i),
        .uv_ok_i   (uv_ok_i),
        .full_on_i (full_on_i),
        .ms_tick_i (ms_tick_i),
        .rst_n_o   (rst_n_o)
    );
endmodule

// File: rtl/rail_en_supervisor_chk.sv
// Property checker for rail_en_supervisor, bound to every instance of it.
module rail_en_supervisor_chk
    import rail_en_supervisor_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en_i,
    input logic [NCH-1:0] uv_ok_i,
    input logic [NCH-1:0] full_on_i,
    input logic [NCH-1:0] gate_en_o,
    input logic           rst_n_o,
    input rs_mode_e       mode,
    input logic [NCH-1:0] drop
);
    // R2
    gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) |=> (gate_en_o == $past(uv_ok_i)));

    // R3
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RUN) |=> ((gate_en_o & ~$past(gate_en_o)) == '0));

    // R4
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_o) |-> $past(&full_on_i));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&full_on_i) |=> !rst_n_o);

    // R6
    uv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gate_en_o & ~$past(uv_ok_i)) == '0));

    // R7
    disable_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rst_n_o);

    // R8
    drop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drop));
endmodule

bind rail_en_supervisor rail_en_supervisor_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .uv_ok_i   (uv_ok_i),
    .full_on_i (full_on_i),
    .gate_en_o (gate_en_o),
    .rst_n_o   (rst_n_o),
    .mode      (mode_w),
    .drop      (drop_w)
);

// File: tb/rail_en_supervisor_bench.sv
// Self-checking bench: flag sweep, hold-timer cases, edge-by-edge shutdown runs.
module rail_en_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 150;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [3:0]  uv_ok_i = '0;
    logic [3:0]  full_on_i = '0;
    logic        ms_tick_i = 1'b1;
    logic [63:0] off_dly_i = '0;
    logic [3:0]  gate_en_o;
    logic        rst_n_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_en_supervisor #(.NCH(4), .DLYW(16), .HOLD_MS(HOLD)) u_rail_en_supervisor (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uv_ok_i(uv_ok_i),
        .full_on_i(full_on_i), .ms_tick_i(ms_tick_i), .off_dly_i(off_dly_i),
        .gate_en_o(gate_en_o), .rst_n_o(rst_n_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: act=%0d exp<%0d cycles", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Advance n edges; return 1 time unit after the last one.
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Edges until rst_n_o is seen high (limit 400).
    task automatic time_release(output int n);
        n = 0;
        for (int i = 1; i <= 400; i++) begin
            edges(1);
            if (rst_n_o && n == 0) n = i;
        end
    endtask

    // Edge-by-edge shutdown run with expected gates from the R8 formula.
    task automatic run_shut(input int d3, input int d2, input int d1, input int d0,
                            input int reen_at, input int uvdrop_at,
                            input logic [3:0] mask, input int len, input string tag);
        int d[4];
        int thr[4];
        int acc;
        logic [3:0] exp_g;
        logic [3:0] uvc;
        d[3] = d3; d[2] = d2; d[1] = d1; d[0] = d0;
        off_dly_i = {16'(d3), 16'(d2), 16'(d1), 16'(d0)};
        acc = 1;
        for (int k = 3; k >= 0; k--) begin
            acc = acc + d[k] + 1;
            thr[k] = acc;
        end
        en_i = 1'b0;
        for (int n = 1; n <= len; n++) begin
            if (reen_at >= 0 && n - 1 >= reen_at) en_i = 1'b1;
            uvc = (uvdrop_at >= 0 && n - 1 >= uvdrop_at) ? (4'hF & ~mask) : 4'hF;
            uv_ok_i = uvc;
            edges(1);
            exp_g = 4'hF;
            for (int k = 0; k < 4; k++) if (n >= thr[k]) exp_g[k] = 1'b0;
            if (uvdrop_at >= 0 && n >= uvdrop_at + 1) exp_g = exp_g & ~mask;
            if (reen_at >= 0 && n >= thr[0] + 2) exp_g = uvc;
            chk(gate_en_o == exp_g, tag, int'(gate_en_o), int'(exp_g));
            chk(rst_n_o == 1'b0, "R7 reset held low in shutdown", int'(rst_n_o), 0);
        end
    endtask

    initial begin
        int t;
        // R1: reset state with active-looking inputs
        en_i = 1'b1; uv_ok_i = 4'hF; full_on_i = 4'hF;
        edges(3);
        chk(gate_en_o == 4'h0, "R1 gates low in reset", int'(gate_en_o), 0);
        chk(rst_n_o == 1'b0, "R1 reset out low in reset", int'(rst_n_o), 0);

        // R3: disabled after reset, flags high, gates stay low
        en_i = 1'b0;
        rst_n = 1'b1;
        edges(5);
        chk(gate_en_o == 4'h0, "R3 off state ignores flags", int'(gate_en_o), 0);
        chk(rst_n_o == 1'b0, "R3 reset low while off", int'(rst_n_o), 0);

        // R2: sweep all flag patterns in the running state
        full_on_i = 4'h0; uv_ok_i = 4'h0; en_i = 1'b1;
        edges(2);
        for (int p = 0; p < 16; p++) begin
            uv_ok_i = 4'(p);
            edges(1);
            chk(gate_en_o == 4'(p), "R2 gate follows own flag", int'(gate_en_o), p);
        end

        // R4: release after HOLD ticks with tick every cycle
        uv_ok_i = 4'hF; full_on_i = 4'hF;
        time_release(t);
        chk(t == HOLD + 1, "R4 release edge count", t, HOLD + 1);

        // R4: no ticks, no release
        full_on_i = 4'h0; edges(1);
        ms_tick_i = 1'b0; full_on_i = 4'hF;
        edges(300);
        chk(rst_n_o == 1'b0, "R4 no release without ticks", int'(rst_n_o), 0);
        ms_tick_i = 1'b1;
        time_release(t);
        chk(t == HOLD + 1, "R4 release once ticks resume", t, HOLD + 1);

        // R5: brief status dropout restarts the count
        full_on_i = 4'b1101; edges(1);
        chk(rst_n_o == 1'b0, "R5 reset low on status drop", int'(rst_n_o), 0);
        full_on_i = 4'hF;
        time_release(t);
        chk(t == HOLD + 1, "R5 full hold after restart", t, HOLD + 1);

        // R6: one flag drops; only its gate falls, reset pulled low
        uv_ok_i = 4'b1011; edges(1);
        chk(gate_en_o == 4'b1011, "R6 only own gate drops", int'(gate_en_o), 11);
        chk(rst_n_o == 1'b0, "R6 reset low on flag drop", int'(rst_n_o), 0);
        uv_ok_i = 4'hF; edges(1);
        chk(gate_en_o == 4'hF, "R6 gate recovers without latch", int'(gate_en_o), 15);
        time_release(t);
        chk(t == HOLD, "R6 release after recovery", t, HOLD);

        // R8 R10: mixed delays, enable re-raised mid shutdown
        run_shut(2, 0, 3, 0, 2, -1, 4'h0, 16, "R8 R10 order mixed delays, re-enable");
        // R9: all-zero delays
        run_shut(0, 0, 0, 0, -1, -1, 4'h0, 8, "R9 zero-delay steps");
        en_i = 1'b1; edges(3);
        chk(gate_en_o == 4'hF, "R10 restart after completed shutdown", int'(gate_en_o), 15);
        // R11: flag lost during a long shutdown
        run_shut(4, 4, 4, 4, -1, 2, 4'b0001, 24, "R11 early drop in shutdown");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule